// File: doc/BRIEF.md
# Motion Parameter Pre-Register

This block sits between a host register port and a pulse-generating motion engine. It keeps two copies of every parameter that shapes a speed profile. The shadow copy is written by the host at any time. The working copy drives the engine and changes only when a move is committed. A start command can also be queued in a shadow flag, so the host can prepare the next move while the current one is still running.

When the engine signals the end of a move and a start is queued, all shadow values are copied into the working set on that same clock edge. A start pulse goes out on the following cycle, so chained moves run back to back with no idle gap. If nothing is queued when a move ends, the block raises a sticky interrupt and a status bit.

Working values persist from one move to the next. The host therefore rewrites only the fields that change, usually just the travel distance.

Top module: `motion_prereg`

## Requirements
- R1: After reset, every shadow and working field reads zero. The start output, the interrupt and all status bits are low, and the engine is idle.
- R2: A host write to a field address 0 to 10 updates that shadow field at the clock edge. The new value reads back at the same address on the next cycle. The working output does not change. The field order is: 0 travel, 1 start speed, 2 top speed, 3 accel rate, 4 decel rate, 5 speed multiplier, 6 ramp-down point, 7 mode, 8 interpolation amount, 9 accel S-range, 10 decel S-range.
- R3: Writing bit 0 to command address 11 while the engine is idle sets the pending flag at that edge. At the next edge the shadow set is copied to the working set, pending clears, running sets, and eng_start_o is high for exactly one cycle.
- R4: If eng_done_i is high while running and a start is pending, the working set is loaded at that edge. eng_start_o is high in the very next cycle and running stays set.
- R5: Shadow writes made while a move runs leave eng_params_o unchanged until the next commit.
- R6: If eng_done_i is high while running and no start is pending, running clears, irq_o goes high and stays high, and no start is issued.
- R7: A start command written while a start is already pending is ignored. It sets a sticky overrun flag, and only one start pulse follows.
- R8: A command write with bit 1 set clears the interrupt. A command write with bit 2 set clears the overrun flag.
- R9: A commit does not clear shadow fields, so working fields that were not rewritten keep their previous values.
- R10: A shadow write on the same edge as a commit puts the old shadow value into the working set. The new value remains in the shadow register.
- R11: eng_done_i while idle has no effect: no start is issued, and neither the interrupt nor the status changes.
- R12: Status address 12 reads bit 0 pending, bit 1 running, bit 2 interrupt, bit 3 overrun. Other bits and unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | ADDR_W | Host register address |
| host_wdata_i | input | PARAM_W | Host write data |
| host_rdata_o | output | PARAM_W | Read data for host_addr_i (combinational) |
| eng_done_i | input | 1 | Engine end-of-move pulse |
| eng_start_o | output | 1 | One-cycle start pulse to the engine |
| eng_params_o | output | NUM_FIELDS*PARAM_W | Working parameter set, field i at bits i*PARAM_W |
| irq_o | output | 1 | Sticky end-of-run interrupt |

## Verification
The bench targets the edges where host writes and engine completion meet. It checks that a done pulse with a queued start produces a start in the very next cycle; a design with a spare pipeline stage would show a one-cycle gap. It checks that a field write landing on the commit edge leaves the old value in the working set; a design that forwards the write would launch the move with the new value. It also checks that a second queued start yields one pulse plus the overrun flag rather than a second move, and that a done pulse while idle leaves the interrupt and status untouched.

// File: rtl/motion_prereg_pkg.sv
package motion_prereg_pkg;
  localparam int NUM_FIELDS = 11;

  typedef enum int {
    FLD_TRAVEL    = 0,
    FLD_V_START   = 1,
    FLD_V_TOP     = 2,
    FLD_ACC_RATE  = 3,
    FLD_DEC_RATE  = 4,
    FLD_V_MULT    = 5,
    FLD_RAMP_DN   = 6,
    FLD_MODE      = 7,
    FLD_INTERP    = 8,
    FLD_S_ACC     = 9,
    FLD_S_DEC     = 10
  } field_e;

  localparam int CMD_ADDR  = 11;
  localparam int STAT_ADDR = 12;

  // command bits
  localparam int CMD_START_BIT   = 0;
  localparam int CMD_IRQ_CLR_BIT = 1;
  localparam int CMD_OVR_CLR_BIT = 2;

  // status bits
  localparam int ST_PEND_BIT = 0;
  localparam int ST_RUN_BIT  = 1;
  localparam int ST_IRQ_BIT  = 2;
  localparam int ST_OVR_BIT  = 3;
  localparam int ST_W        = 4;
endpackage

// File: rtl/prereg_bank.sv
module prereg_bank #(
  parameter int N = 11,
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         commit_i,
  output logic [N*W-1:0] pre_o,
  output logic [N*W-1:0] work_o
);
  for (genvar g = 0; g < N; g++) begin : g_field
    logic [W-1:0] pre_q, work_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pre_q <= '0;
      else if (wr_en_i[g]) pre_q <= wr_data_i;
    end

    // working copy takes the pre-edge shadow value
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) work_q <= '0;
      else if (commit_i) work_q <= pre_q;
    end

    assign pre_o[g*W +: W]  = pre_q;
    assign work_o[g*W +: W] = work_q;
  end
endmodule

// File: rtl/start_sequencer.sv
module start_sequencer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_req_i,
  input  logic irq_clr_i,
  input  logic ovr_clr_i,
  input  logic done_i,
  output logic commit_o,
  output logic start_o,
  output logic pending_o,
  output logic running_o,
  output logic irq_o,
  output logic overrun_o
);
  logic pending_q, running_q, irq_q, overrun_q, start_q;
  logic commit;

  assign commit = pending_q & (~running_q | done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      running_q <= 1'b0;
      irq_q     <= 1'b0;
      overrun_q <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      start_q <= commit;

      if (commit) pending_q <= 1'b0;
      else if (start_req_i) pending_q <= 1'b1;

      if (commit) running_q <= 1'b1;
      else if (done_i) running_q <= 1'b0;

      // set has priority over clear
      if (done_i && running_q && !pending_q) irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;

      if (start_req_i && pending_q) overrun_q <= 1'b1;
      else if (ovr_clr_i) overrun_q <= 1'b0;
    end
  end

  assign commit_o  = commit;
  assign start_o   = start_q;
  assign pending_o = pending_q;
  assign running_o = running_q;
  assign irq_o     = irq_q;
  assign overrun_o = overrun_q;
endmodule

// File: rtl/host_readback.sv
module host_readback #(
  parameter int N      = 11,
  parameter int W      = 24,
  parameter int ADDR_W = 4,
  parameter int STAT_A = 12,
  parameter int ST_W   = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N*W-1:0]    pre_i,
  input  logic [ST_W-1:0]   status_i,
  output logic [W-1:0]      rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (int'(addr_i) < N) rdata_o = pre_i[int'(addr_i)*W +: W];
    else if (int'(addr_i) == STAT_A) rdata_o[ST_W-1:0] = status_i;
  end
endmodule

// File: rtl/motion_prereg.sv
module motion_prereg
  import motion_prereg_pkg::*;
#(
  parameter int PARAM_W = 24,
  parameter int ADDR_W  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       host_we_i,
  input  logic [ADDR_W-1:0]          host_addr_i,
  input  logic [PARAM_W-1:0]         host_wdata_i,
  output logic [PARAM_W-1:0]         host_rdata_o,
  input  logic                       eng_done_i,
  output logic                       eng_start_o,
  output logic [NUM_FIELDS*PARAM_W-1:0] eng_params_o,
  output logic                       irq_o
);
  localparam int N = NUM_FIELDS;

  logic [N-1:0]         fld_we;
  logic                 cmd_we;
  logic                 commit;
  logic                 pending_q, running_q, overrun_q;
  logic [N*PARAM_W-1:0] pre_flat;
  logic [ST_W-1:0]      status;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign fld_we[g] = host_we_i && (int'(host_addr_i) == g);
  end
  assign cmd_we = host_we_i && (int'(host_addr_i) == CMD_ADDR);

  prereg_bank #(.N(N), .W(PARAM_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (fld_we),
    .wr_data_i(host_wdata_i),
    .commit_i (commit),
    .pre_o    (pre_flat),
    .work_o   (eng_params_o)
  );

  start_sequencer u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_req_i(cmd_we && host_wdata_i[CMD_START_BIT]),
    .irq_clr_i  (cmd_we && host_wdata_i[CMD_IRQ_CLR_BIT]),
    .ovr_clr_i  (cmd_we && host_wdata_i[CMD_OVR_CLR_BIT]),
    .done_i     (eng_done_i),
    .commit_o   (commit),
    .start_o    (eng_start_o),
    .pending_o  (pending_q),
    .running_o  (running_q),
    .irq_o      (irq_o),
    .overrun_o  (overrun_q)
  );

  always_comb begin
    status              = '0;
    status[ST_PEND_BIT] = pending_q;
    status[ST_RUN_BIT]  = running_q;
    status[ST_IRQ_BIT]  = irq_o;
    status[ST_OVR_BIT]  = overrun_q;
  end

  host_readback #(
    .N(N), .W(PARAM_W), .ADDR_W(ADDR_W), .STAT_A(STAT_ADDR), .ST_W(ST_W)
  ) u_rb (
    .addr_i  (host_addr_i),
    .pre_i   (pre_flat),
    .status_i(status),
    .rdata_o (host_rdata_o)
  );
endmodule

// File: rtl/motion_prereg_chk.sv
module motion_prereg_chk
  import motion_prereg_pkg::*;
#(
  parameter int PARAM_W = 24,
  parameter int ADDR_W  = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          host_we_i,
  input logic [ADDR_W-1:0]             host_addr_i,
  input logic [PARAM_W-1:0]            host_wdata_i,
  input logic                          eng_start_o,
  input logic [NUM_FIELDS*PARAM_W-1:0] eng_params_o,
  input logic                          irq_o,
  input logic                          pending,
  input logic                          running,
  input logic                          overrun
);
  logic ovr_clr;
  assign ovr_clr = host_we_i && (int'(host_addr_i) == CMD_ADDR) && host_wdata_i[CMD_OVR_CLR_BIT];

  assert_start_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);

  assert_start_running_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> (running && !pending));

  assert_work_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_start_o |-> $stable(eng_params_o));

  assert_irq_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !running);

  assert_overrun_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun && !ovr_clr) |=> overrun);

  assert_idle_no_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && !pending) |=> !eng_start_o);
endmodule

bind motion_prereg motion_prereg_chk #(.PARAM_W(PARAM_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_we_i   (host_we_i),
  .host_addr_i (host_addr_i),
  .host_wdata_i(host_wdata_i),
  .eng_start_o (eng_start_o),
  .eng_params_o(eng_params_o),
  .irq_o       (irq_o),
  .pending     (pending_q),
  .running     (running_q),
  .overrun     (overrun_q)
);

// File: tb/motion_prereg_test.sv
module motion_prereg_test;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 24;
  localparam int AW = 4;
  localparam int N  = 11;
  localparam int CMD  = 11;
  localparam int STAT = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic done = 1'b0;
  logic start;
  logic [N*W-1:0] params;
  logic irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [W-1:0] pre_m [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  motion_prereg #(.PARAM_W(W), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .eng_done_i(done),
    .eng_start_o(start), .eng_params_o(params), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a < N) pre_m[a] = d;
  endtask

  task automatic rd(input int a, output logic [W-1:0] d);
    addr = AW'(a);
    #1;
    d = rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic chk_status(input string tag, input logic [W-1:0] exp);
    logic [W-1:0] v;
    rd(STAT, v);
    chk(tag, v, exp);
  endtask

  task automatic chk_work(input string tag);
    for (int i = 0; i < N; i++) chk(tag, params[i*W +: W], pre_m[i]);
  endtask

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] old3;
    for (int i = 0; i < N; i++) pre_m[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(a, v);
      chk("R1 readback", v, '0);
    end
    chk("R1 params", params[W-1:0], '0);
    chk("R1 start", W'(start), '0);
    chk("R1 irq", W'(irq), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 sweep: write each field, read back all fields
    for (int i = 0; i < N; i++) begin
      wr(i, W'(i * 24'h010101 + 24'h5A));
      for (int j = 0; j < N; j++) begin
        rd(j, v);
        chk("R2 readback", v, pre_m[j]);
      end
      for (int j = 0; j < N; j++) chk("R2 work untouched", params[j*W +: W], '0);
    end
    rd(CMD, v);  chk("R12 cmd reads zero", v, '0);
    rd(13, v);   chk("R12 unused reads zero", v, '0);

    // R3 start from idle
    wr(CMD, 24'h1);
    chk("R3 no start yet", W'(start), '0);
    chk_status("R3 pending", 24'h1);
    for (int j = 0; j < N; j++) chk("R3 work not yet", params[j*W +: W], '0);
    @(negedge clk);
    chk("R3 start pulse", W'(start), 24'h1);
    chk_work("R3 work loaded");
    chk_status("R3 running", 24'h2);
    @(negedge clk);
    chk("R3 start single", W'(start), '0);

    // R5 shadow writes during run
    for (int i = 0; i < N; i++) begin
      v = params[i*W +: W];
      wr(i, W'(24'hA00000 + i * 24'h111));
      chk("R5 work held", params[i*W +: W], v);
    end

    // R7 queue then overrun
    wr(CMD, 24'h1);
    chk_status("R7 pending while running", 24'h3);
    wr(CMD, 24'h1);
    chk_status("R7 overrun set", 24'hB);

    // R4 chained start
    pulse_done();
    chk("R4 start next cycle", W'(start), 24'h1);
    chk_work("R4 work chained");
    chk_status("R4 still running", 24'hA);
    chk("R4 no irq", W'(irq), '0);
    @(negedge clk);
    chk("R7 single start", W'(start), '0);
    chk_status("R7 overrun sticky", 24'hA);
    wr(CMD, 24'h4);
    chk_status("R8 overrun cleared", 24'h2);

    // R9 only travel rewritten
    wr(0, 24'h00BEEF);
    wr(CMD, 24'h1);
    pulse_done();
    chk("R9 start", W'(start), 24'h1);
    chk_work("R9 persist");
    rd(5, v); chk("R9 shadow kept", v, pre_m[5]);

    // R6 done without queue
    @(negedge clk);
    pulse_done();
    chk("R6 no start", W'(start), '0);
    chk("R6 irq", W'(irq), 24'h1);
    chk_status("R6 status", 24'h4);

    // R11 done while idle
    pulse_done();
    chk("R11 no start", W'(start), '0);
    chk_status("R11 status unchanged", 24'h4);
    wr(CMD, 24'h2);
    chk("R8 irq cleared", W'(irq), '0);
    pulse_done();
    chk("R11 irq stays low", W'(irq), '0);
    chk_status("R11 idle status", 24'h0);

    // R10 write coinciding with commit
    wr(CMD, 24'h1);
    @(negedge clk);
    chk("R10 first start", W'(start), 24'h1);
    wr(CMD, 24'h1);
    old3 = pre_m[3];
    @(negedge clk);
    done = 1'b1; we = 1'b1; addr = AW'(3); wdata = 24'h7E7E7E;
    @(negedge clk);
    done = 1'b0; we = 1'b0;
    chk("R10 start", W'(start), 24'h1);
    chk("R10 work old", params[3*W +: W], old3);
    rd(3, v); chk("R10 shadow new", v, 24'h7E7E7E);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule